// File: doc/BRIEF.md
# Fractional Phase-Selecting Accumulator Synthesizer

This block is a cycle-level digital model of a single-path frequency synthesizer that builds its output by picking edges out of a set of equally spaced oscillator phases. A free-running tick counter stands in for the oscillator. One clock cycle of the block is one tick, the spacing between adjacent phases. The low `INT_W` bits of the counter name the phase that is current in that cycle. A control word with `INT_W` integer bits and `FRAC_W` fractional bits gives the desired output period in ticks. With the defaults (32 phases, 5 + 5 bits), a 4.9 ns target on a 0.2 ns tick is 24.5 ticks, which is code 784 (binary 11000.10000).

The synthesizer keeps a phase accumulator. The integer field of the accumulator is the phase select. When the tick counter reaches the selected phase, the block makes an output edge and adds the control word to the accumulator. The new integer field then names the phase for the following edge. When the fraction bits are nonzero, their carry lengthens some intervals by one tick, so the output frequency is a time average. That frequency is inversely proportional to the control word. The output waveform rises at each selected edge and falls at the phase found by adding half the word, which gives a near-even duty cycle. Each edge is also reported as a one-cycle strobe, stamped with the tick count at which it occurred.

Top module: `fa_phase_synth`

## Requirements
- R1: While `rst` is high, `clk_out`, `edge_stb` and `phase_sel` are 0, and the control word returns to its reset value (code 784). The first edge after reset is stamped at tick 0.
- R2: Each interval between consecutive edge stamps is floor(W) ticks, where W = code/2^FRAC_W is the control word. When the fraction bits are nonzero, an interval may instead be floor(W)+1 ticks.
- R3: Over any 32 consecutive intervals, the summed length in ticks is within one tick of the control word code value (32·W).
- R4: Each edge's stamp, taken modulo 2^INT_W, equals the `phase_sel` value shown before that edge. With code 784 from reset, the stamps run 0, 24, 49, and `phase_sel` reads 24 after the first edge.
- R5: `phase_sel` changes only in the cycle in which `edge_stb` is high.
- R6: `clk_out` rises together with each `edge_stb`. It stays high for floor(H) or floor(H)+1 cycles, where H = (code>>1)/2^FRAC_W; when the fraction bits of code>>1 are zero, it stays high for exactly floor(H) cycles. It then stays low until the next edge.
- R7: `edge_stb` is a single-cycle pulse, and consecutive strobes are between 2 and 2^INT_W cycles apart.
- R8: A word loaded with `word_load` governs the interval that begins at the first edge whose selecting tick comes after the load cycle. The interval already in progress keeps the old length.
- R9: A load whose integer field (bits [WORD_W-1:FRAC_W]) is below 2 is ignored, and the previous word stays in effect.
- R10: A word with integer field 2^INT_W-1 and a nonzero fraction produces some intervals of a full 2^INT_W ticks, in which the select returns to the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one cycle is one phase step |
| rst | input | 1 | Synchronous active-high reset |
| word_load | input | 1 | Request to load `word_in` as the control word |
| word_in | input | INT_W+FRAC_W | Candidate control word, fixed point with FRAC_W fraction bits |
| clk_out | output | 1 | Synthesized output waveform |
| phase_sel | output | INT_W | Phase selected for the next edge |
| edge_stb | output | 1 | One-cycle pulse for each output edge |
| edge_stamp | output | STAMP_W | Tick count at which the latest edge was selected |

## Verification
Five properties are checked on every cycle:
- each strobe is a single-cycle pulse;
- the spacing between strobes stays between 2 and 2^INT_W cycles;
- each stamp lands on the select shown before it;
- the select holds still between edges;
- `clk_out` rises with every strobe.

Only the bench's scenarios can show the properties that depend on a word's value, because they need a measurement over many intervals. These are the floor and ceiling bound on each interval, the 32-interval average, the high-time limits, the rejection of words below two, when a newly loaded word takes effect, and the 32-tick wrap intervals near the top of the range.

// File: rtl/fa_synth_pkg.sv
package fa_synth_pkg;
  // Default geometry: 32 phases, 5 integer + 5 fraction bits.
  localparam int INT_W_DEF    = 5;
  localparam int FRAC_W_DEF   = 5;
  localparam int STAMP_W_DEF  = 16;
  localparam int MIN_INT_DEF  = 2;
  // 24.5 ticks = 11000.10000b
  localparam int RST_WORD_DEF = 784;
endpackage

// File: rtl/fa_tick_base.sv
module fa_tick_base #(
  parameter int STAMP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  output logic [STAMP_W-1:0] stamp_o
);
  logic [STAMP_W-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (rst) stamp_q <= '0;
    else     stamp_q <= stamp_q + 1'b1;
  end

  assign stamp_o = stamp_q;
endmodule

// File: rtl/fa_word_reg.sv
module fa_word_reg #(
  parameter int INT_W    = 5,
  parameter int FRAC_W   = 5,
  parameter int MIN_INT  = 2,
  parameter int RST_WORD = 784,
  localparam int WORD_W  = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic              accept;
  logic [WORD_W-1:0] word_q;

  generate
    if (MIN_INT == 0) begin : g_any
      assign accept = load_i;
    end else begin : g_min
      // Integer part must reach the minimum number of ticks per edge.
      assign accept = load_i && (word_i[WORD_W-1:FRAC_W] >= INT_W'(MIN_INT));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         word_q <= WORD_W'(RST_WORD);
    else if (accept) word_q <= word_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/fa_phase_accum.sv
module fa_phase_accum #(
  parameter int INT_W  = 5,
  parameter int FRAC_W = 5,
  localparam int WORD_W = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [INT_W-1:0]  rise_sel_o,
  output logic [INT_W-1:0]  fall_sel_o
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] half_pos;
  logic [INT_W-1:0]  fall_q;

  // Falling edge sits half a word past the edge now being taken.
  assign half_pos = acc_q + (word_i >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      fall_q <= '0;
    end else if (step_i) begin
      acc_q  <= acc_q + word_i;
      fall_q <= half_pos[WORD_W-1:FRAC_W];
    end
  end

  assign rise_sel_o = acc_q[WORD_W-1:FRAC_W];
  assign fall_sel_o = fall_q;
endmodule

// File: rtl/fa_edge_former.sv
module fa_edge_former #(
  parameter int INT_W   = 5,
  parameter int STAMP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STAMP_W-1:0] stamp_i,
  input  logic [INT_W-1:0]   rise_sel_i,
  input  logic [INT_W-1:0]   fall_sel_i,
  output logic               hit_o,
  output logic               clk_out_o,
  output logic               edge_stb_o,
  output logic [STAMP_W-1:0] edge_stamp_o
);
  logic [INT_W-1:0]   phase;
  logic               fall_hit;
  logic               out_q;
  logic               stb_q;
  logic [STAMP_W-1:0] est_q;

  assign phase    = stamp_i[INT_W-1:0];
  assign hit_o    = (phase == rise_sel_i);
  assign fall_hit = out_q && (phase == fall_sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      stb_q <= 1'b0;
      est_q <= '0;
    end else begin
      stb_q <= hit_o;
      if (hit_o) begin
        out_q <= 1'b1;
        est_q <= stamp_i;
      end else if (fall_hit) begin
        out_q <= 1'b0;
      end
    end
  end

  assign clk_out_o    = out_q;
  assign edge_stb_o   = stb_q;
  assign edge_stamp_o = est_q;
endmodule

// File: rtl/fa_phase_synth.sv
module fa_phase_synth
  import fa_synth_pkg::*;
#(
  parameter int INT_W    = INT_W_DEF,
  parameter int FRAC_W   = FRAC_W_DEF,
  parameter int STAMP_W  = STAMP_W_DEF,
  parameter int MIN_INT  = MIN_INT_DEF,
  parameter int RST_WORD = RST_WORD_DEF,
  localparam int WORD_W  = INT_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_load,
  input  logic [WORD_W-1:0]  word_in,
  output logic               clk_out,
  output logic [INT_W-1:0]   phase_sel,
  output logic               edge_stb,
  output logic [STAMP_W-1:0] edge_stamp
);
  logic [STAMP_W-1:0] stamp;
  logic [WORD_W-1:0]  word;
  logic [INT_W-1:0]   rise_sel;
  logic [INT_W-1:0]   fall_sel;
  logic               hit;

  fa_tick_base #(.STAMP_W(STAMP_W)) tick_i (
    .clk     (clk),
    .rst     (rst),
    .stamp_o (stamp)
  );

  fa_word_reg #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_INT(MIN_INT), .RST_WORD(RST_WORD)
  ) word_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (word_load),
    .word_i (word_in),
    .word_o (word)
  );

  fa_phase_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) accum_i (
    .clk        (clk),
    .rst        (rst),
    .step_i     (hit),
    .word_i     (word),
    .rise_sel_o (rise_sel),
    .fall_sel_o (fall_sel)
  );

  fa_edge_former #(.INT_W(INT_W), .STAMP_W(STAMP_W)) edge_i (
    .clk          (clk),
    .rst          (rst),
    .stamp_i      (stamp),
    .rise_sel_i   (rise_sel),
    .fall_sel_i   (fall_sel),
    .hit_o        (hit),
    .clk_out_o    (clk_out),
    .edge_stb_o   (edge_stb),
    .edge_stamp_o (edge_stamp)
  );

  assign phase_sel = rise_sel;
endmodule

// File: rtl/fa_phase_synth_chk.sv
module fa_phase_synth_chk #(
  parameter int INT_W   = 5,
  parameter int STAMP_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               clk_out,
  input logic [INT_W-1:0]   phase_sel,
  input logic               edge_stb,
  input logic [STAMP_W-1:0] edge_stamp
);
  localparam int PHASES = 1 << INT_W;
  localparam int CNT_W  = INT_W + 2;

  logic [CNT_W-1:0] since_q;
  logic             seen_q;

  // Cycles since the previous strobe, saturating.
  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (edge_stb) begin
      since_q <= CNT_W'(1);
      seen_q  <= 1'b1;
    end else if (since_q != {CNT_W{1'b1}}) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    edge_stb |=> !edge_stb);

  p_strobe_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    (edge_stb && seen_q) |-> (since_q >= CNT_W'(2) && since_q <= CNT_W'(PHASES)));

  p_stamp_on_select_r4: assert property (@(posedge clk) disable iff (rst)
    edge_stb |-> (edge_stamp[INT_W-1:0] == $past(phase_sel)));

  p_select_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !edge_stb |-> $stable(phase_sel));

  p_rise_with_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    edge_stb |-> $rose(clk_out));
endmodule

bind fa_phase_synth fa_phase_synth_chk #(.INT_W(INT_W), .STAMP_W(STAMP_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .clk_out    (clk_out),
  .phase_sel  (phase_sel),
  .edge_stb   (edge_stb),
  .edge_stamp (edge_stamp)
);

// File: tb/fa_phase_synth_tb_top.sv
module fa_phase_synth_tb_top;
  localparam int INT_W   = 5;
  localparam int FRAC_W  = 5;
  localparam int STAMP_W = 16;
  localparam int WORD_W  = INT_W + FRAC_W;
  localparam int NV      = 8;

  // word code, interval min/max, high-time min/max (ticks)
  localparam int VEC_W    [NV] = '{784, 64, 1023, 1008, 100, 512, 97, 65};
  localparam int VEC_IMIN [NV] = '{ 24,  2,   31,   31,   3,  16,  3,  2};
  localparam int VEC_IMAX [NV] = '{ 25,  2,   32,   32,   4,  16,  4,  3};
  localparam int VEC_HMIN [NV] = '{ 12,  1,   15,   15,   1,   8,  1,  1};
  localparam int VEC_HMAX [NV] = '{ 13,  1,   16,   16,   2,   8,  2,  1};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               word_load = 1'b0;
  logic [WORD_W-1:0]  word_in = '0;
  logic               clk_out;
  logic [INT_W-1:0]   phase_sel;
  logic               edge_stb;
  logic [STAMP_W-1:0] edge_stamp;

  int n_chk  = 0;
  int n_fail = 0;
  bit hung   = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fa_phase_synth #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .STAMP_W(STAMP_W), .MIN_INT(2), .RST_WORD(784)
  ) dut_i (
    .clk(clk), .rst(rst), .word_load(word_load), .word_in(word_in),
    .clk_out(clk_out), .phase_sel(phase_sel), .edge_stb(edge_stb), .edge_stamp(edge_stamp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe(output int st, output int sel);
    int g = 0;
    st = 0;
    sel = 0;
    while (!hung) begin
      @(negedge clk);
      g++;
      if (edge_stb) begin
        st  = int'(edge_stamp);
        sel = int'(phase_sel);
        return;
      end
      if (g > 200) begin
        hung = 1'b1;
        check(1'b0, "watchdog edge wait", g, 200);
      end
    end
  endtask

  task automatic load_word(input int v);
    word_in   = WORD_W'(v);
    word_load = 1'b1;
    @(negedge clk);
    word_load = 1'b0;
  endtask

  task automatic measure(input int n, output int sum, output int imin, output int imax,
                         output int hmin, output int hmax, output int n32, output int sel_bad);
    int ps, psel, st, sel, hc, iv;
    sum = 0; imin = 1000; imax = 0; hmin = 1000; hmax = 0; n32 = 0; sel_bad = 0;
    wait_strobe(ps, psel);
    for (int i = 0; i < n && !hung; i++) begin
      hc = 0;
      while (clk_out && hc < 100) begin
        hc++;
        @(negedge clk);
      end
      wait_strobe(st, sel);
      iv = (st - ps) & 16'hFFFF;
      if ((st & ((1 << INT_W) - 1)) != psel) sel_bad++;
      sum += iv;
      if (iv < imin) imin = iv;
      if (iv > imax) imax = iv;
      if (hc < hmin) hmin = hc;
      if (hc > hmax) hmax = hc;
      if (iv == 32) n32++;
      ps = st;
      psel = sel;
    end
  endtask

  task automatic reset_checks();
    int st, sel;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(clk_out == 1'b0, "R1 clk_out in reset", int'(clk_out), 0);
    check(edge_stb == 1'b0, "R1 edge_stb in reset", int'(edge_stb), 0);
    check(phase_sel == '0, "R1 phase_sel in reset", int'(phase_sel), 0);
    rst = 1'b0;
    wait_strobe(st, sel);
    check(st == 0, "R1 first stamp", st, 0);
    check(sel == 24, "R4 select after first edge", sel, 24);
    wait_strobe(st, sel);
    check(st == 24, "R4 second stamp", st, 24);
    wait_strobe(st, sel);
    check(st == 49, "R2 third stamp", st, 49);
  endtask

  initial begin
    int d0, d1, sum, imin, imax, hmin, hmax, n32, sbad, sa, sb, sc;
    reset_checks();

    for (int v = 0; v < NV && !hung; v++) begin
      load_word(VEC_W[v]);
      wait_strobe(d0, d1);
      measure(32, sum, imin, imax, hmin, hmax, n32, sbad);
      check(imin >= VEC_IMIN[v], "R2 interval low bound", imin, VEC_IMIN[v]);
      check(imax <= VEC_IMAX[v], "R2 interval high bound", imax, VEC_IMAX[v]);
      check((sum - VEC_W[v] <= 1) && (VEC_W[v] - sum <= 1), "R3 32-interval sum", sum, VEC_W[v]);
      check(hmin >= VEC_HMIN[v] && hmax <= VEC_HMAX[v], "R6 high time", hmax, VEC_HMAX[v]);
      check(sbad == 0, "R4 stamp on select", sbad, 0);
      if (VEC_IMAX[v] == 32)
        check(n32 > 0, "R10 full-wrap intervals", n32, 1);
    end

    // R8: a load right after an edge leaves the running interval alone
    wait_strobe(sa, d1);
    load_word(512);
    wait_strobe(sb, d1);
    wait_strobe(sc, d1);
    check(((sb - sa) & 16'hFFFF) >= 2 && ((sb - sa) & 16'hFFFF) <= 3,
          "R8 interval in progress keeps old word", (sb - sa) & 16'hFFFF, 2);
    check(((sc - sb) & 16'hFFFF) == 16, "R8 new word after next edge", (sc - sb) & 16'hFFFF, 16);

    // R9: integer part 1 and 0 are refused
    load_word(50);
    wait_strobe(d0, d1);
    measure(4, sum, imin, imax, hmin, hmax, n32, sbad);
    check(imin == 16 && imax == 16, "R9 word 1.5625 ignored", imax, 16);
    load_word(20);
    wait_strobe(d0, d1);
    measure(4, sum, imin, imax, hmin, hmax, n32, sbad);
    check(imin == 16 && imax == 16, "R9 word 0.625 ignored", imax, 16);

    // R1: reset mid-run restores state and the reset word
    @(negedge clk);
    reset_checks();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule